// File: doc/BRIEF.md
# Rate-Lock Pulse Controller

This block steers an external loop filter so that a clock-crossing FIFO stays near half full. It compares the write pointer with the read pointer. On every tick of a programmable divided clock it drives one of two correction outputs: raise when the FIFO is overfull, lower when it is underfull, and neither when the fill sits exactly at the nominal point. After a rising edge on the software start input, the block first spends a fixed number of ticks raising unconditionally. This charges the filter. Software should raise start only after the upstream frame aligner has reached its first alignment, because the FIFO carries no traffic before then.

A run of consecutive ticks with the same correction direction forms a burst. The block measures two quantities. The window is the number of pulses in a burst. The beat period is the number of quiet ticks between the end of one burst and the start of the next. Each measurement is compared against a programmed threshold and held in its own convergence flag. When both flags are set together, the block reports lock.

Top module: `rate_lock_ctrl`

## Requirements
- R1: While rst_ni is low, up_o, dn_o, win_conv_o, beat_conv_o and lock_o are all 0, independent of the clock.
- R2: Ticks occur once every 2^div_sel_i clock cycles, counted from the start edge. Each correction level is updated only on a tick and holds for one full tick period. The charge interval therefore keeps up_o high for exactly CHARGE_TICKS × 2^div_sel_i cycles.
- R3: A rising edge of start_i begins the charge interval. During the charge interval up_o is high and the pointers are ignored. When start_i is low, the block is idle: up_o and dn_o are 0 and both flags clear within two cycles.
- R4: After charging, on each tick the fill (wr_ptr_i − rd_ptr_i) mod 2^AW is evaluated. A fill above 2^(AW−1) gives up_o=1. A fill below 2^(AW−1) gives dn_o=1. A fill equal to 2^(AW−1) gives neither.
- R5: up_o and dn_o are never both 1.
- R6: When a burst ends, win_conv_o is set to (window < 2 × win_min_i). A burst ends on the first tick with no correction or with the opposite direction.
- R7: When a burst starts, beat_conv_o is set to (gap ≥ beat_max_i), where gap is the number of quiet ticks since the previous burst. The first burst after charging is not evaluated. A direction reversal counts as a gap of 0.
- R8: The gap counter saturates at 2^BW − 1 and does not wrap.
- R9: lock_o is 1 exactly when win_conv_o and beat_conv_o are both 1.
- R10: A flag keeps its value until its next evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Software arm; its rising edge starts charging, low means idle |
| div_sel_i | input | DIVW | Tick period select, 2^div_sel_i cycles |
| wr_ptr_i | input | AW | FIFO write pointer |
| rd_ptr_i | input | AW | FIFO read pointer |
| win_min_i | input | WW | Minimum window threshold |
| beat_max_i | input | BW | Maximum beat period threshold |
| up_o | output | 1 | Raise correction pulse |
| dn_o | output | 1 | Lower correction pulse |
| win_conv_o | output | 1 | Window convergence flag |
| beat_conv_o | output | 1 | Beat period convergence flag |
| lock_o | output | 1 | Both flags set |

## Verification
A direction decision appears on up_o/dn_o at the tick edge that sees the pointers. With div_sel_i = 0 that is the next clock edge. With larger settings it can be up to 2^div_sel_i edges later, so the bench waits two full tick periods before it compares. Each flag is registered at the tick that ends or starts a burst. The bench drives one decision per cycle on the falling edge and reads the flag at the falling edge that follows the evaluating tick. The charge interval is traced cycle by cycle from the start edge: the first raise is due 2^div_sel_i edges after the arming edge.

// File: rtl/rlc_pkg.sv
`timescale 1ns/1ps
package rlc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_CHARGE = 2'b01,
    ST_TRACK  = 2'b10
  } rlc_state_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } rlc_dir_e;
endpackage

// File: rtl/rlc_divider.sv
`timescale 1ns/1ps
module rlc_divider #(
  parameter int DIVW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DIVW-1:0] div_sel_i,
  output logic            tick_o
);
  localparam int CW = (1 << DIVW) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // limit = 2^sel - 1 as a run of ones
  always_comb begin
    limit = '0;
    for (int i = 0; i < CW; i++) limit[i] = (i < int'(div_sel_i));
  end

  assign tick_o = en_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_sel_i != '0) |=> (!tick_o || div_sel_i != $past(div_sel_i))); // R2
endmodule

// File: rtl/rlc_fill_cmp.sv
`timescale 1ns/1ps
module rlc_fill_cmp
  import rlc_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [AW-1:0] rd_ptr_i,
  output rlc_dir_e      dir_o
);
  localparam logic [AW-1:0] NOMINAL = AW'(1) << (AW - 1);

  logic [AW-1:0] fill;

  assign fill = wr_ptr_i - rd_ptr_i;

  always_comb begin
    if (fill > NOMINAL)      dir_o = DIR_UP;
    else if (fill < NOMINAL) dir_o = DIR_DN;
    else                     dir_o = DIR_NONE;
  end
endmodule

// File: rtl/rlc_fsm.sv
`timescale 1ns/1ps
module rlc_fsm
  import rlc_pkg::*;
#(
  parameter int CHARGE_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tick_i,
  input  rlc_dir_e   dir_i,
  output logic       up_o,
  output logic       dn_o,
  output rlc_state_e state_o
);
  localparam int CHW = $clog2(CHARGE_TICKS + 1);
  localparam logic [CHW-1:0] CHG_LAST = CHW'(CHARGE_TICKS - 1);

  rlc_state_e     state_q;
  logic [CHW-1:0] chg_q;
  logic           start_q;
  logic           up_q, dn_q;
  logic           start_rise;

  assign start_rise = start_i && !start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chg_q   <= '0;
      start_q <= 1'b0;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
    end else begin
      start_q <= start_i;
      if (!start_i) begin
        state_q <= ST_IDLE;
        chg_q   <= '0;
        up_q    <= 1'b0;
        dn_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (start_rise) begin
              state_q <= ST_CHARGE;
              chg_q   <= '0;
            end
          end
          ST_CHARGE: begin
            if (tick_i) begin
              up_q <= 1'b1;
              dn_q <= 1'b0;
              if (chg_q == CHG_LAST) state_q <= ST_TRACK;
              else                   chg_q   <= chg_q + 1'b1;
            end
          end
          ST_TRACK: begin
            if (tick_i) begin
              up_q <= (dir_i == DIR_UP);
              dn_q <= (dir_i == DIR_DN);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign up_o    = up_q;
  assign dn_o    = dn_q;
  assign state_o = state_q;

  AST_CHARGE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHARGE && tick_i && start_i) |=> (up_q && !dn_q)); // R3
  AST_PULSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && start_i) |=> ($stable(up_q) && $stable(dn_q))); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!up_q && !dn_q)); // R3
endmodule

// File: rtl/rlc_meter.sv
`timescale 1ns/1ps
module rlc_meter
  import rlc_pkg::*;
#(
  parameter int WW = 8,
  parameter int BW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          track_i,
  input  logic          tick_i,
  input  rlc_dir_e      dir_i,
  input  logic [WW-1:0] win_min_i,
  input  logic [BW-1:0] beat_max_i,
  output logic          win_conv_o,
  output logic          beat_conv_o
);
  localparam logic [WW-1:0] WIN_MAX = '1;
  localparam logic [BW-1:0] GAP_MAX = '1;

  rlc_dir_e      prev_q;
  logic [WW-1:0] win_q;
  logic [BW-1:0] gap_q;
  logic          seen_q;
  logic          wc_q, bc_q;

  logic ev, active, was, same, win_small;

  assign ev        = tick_i && track_i;
  assign active    = (dir_i != DIR_NONE);
  assign was       = (prev_q != DIR_NONE);
  assign same      = active && (dir_i == prev_q);
  assign win_small = ({1'b0, win_q} < {win_min_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= DIR_NONE;
      win_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
      wc_q   <= 1'b0;
      bc_q   <= 1'b0;
    end else begin
      if (clr_i) begin
        wc_q <= 1'b0;
        bc_q <= 1'b0;
      end
      if (!track_i) begin
        prev_q <= DIR_NONE;
        win_q  <= '0;
        gap_q  <= '0;
        seen_q <= 1'b0;
      end else if (ev) begin
        prev_q <= dir_i;
        if (same) begin
          if (win_q != WIN_MAX) win_q <= win_q + 1'b1;
        end else if (active && was) begin
          // reversal: close one burst, open the next with zero gap
          wc_q   <= win_small;
          seen_q <= 1'b1;
          bc_q   <= (beat_max_i == '0);
          win_q  <= WW'(1);
          gap_q  <= '0;
        end else if (active) begin
          if (seen_q) bc_q <= (gap_q >= beat_max_i);
          win_q <= WW'(1);
          gap_q <= '0;
        end else if (was) begin
          wc_q   <= win_small;
          seen_q <= 1'b1;
          gap_q  <= BW'(1);
        end else if (gap_q != GAP_MAX) begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  assign win_conv_o  = wc_q;
  assign beat_conv_o = bc_q;

  AST_GAP_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && !active && !was && gap_q == GAP_MAX) |=> (gap_q == GAP_MAX)); // R8
  AST_FLAGS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!wc_q && !bc_q)); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev && !clr_i) |=> ($stable(wc_q) && $stable(bc_q))); // R10
endmodule

// File: rtl/rate_lock_ctrl.sv
`timescale 1ns/1ps
module rate_lock_ctrl
  import rlc_pkg::*;
#(
  parameter int AW           = 5,
  parameter int DIVW         = 3,
  parameter int WW           = 8,
  parameter int BW           = 16,
  parameter int CHARGE_TICKS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [DIVW-1:0] div_sel_i,
  input  logic [AW-1:0]   wr_ptr_i,
  input  logic [AW-1:0]   rd_ptr_i,
  input  logic [WW-1:0]   win_min_i,
  input  logic [BW-1:0]   beat_max_i,
  output logic            up_o,
  output logic            dn_o,
  output logic            win_conv_o,
  output logic            beat_conv_o,
  output logic            lock_o
);
  rlc_state_e state;
  rlc_dir_e   dir;
  logic       tick;

  rlc_divider #(.DIVW(DIVW)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state != ST_IDLE),
    .div_sel_i (div_sel_i),
    .tick_o    (tick)
  );

  rlc_fill_cmp #(.AW(AW)) u_cmp (
    .wr_ptr_i (wr_ptr_i),
    .rd_ptr_i (rd_ptr_i),
    .dir_o    (dir)
  );

  rlc_fsm #(.CHARGE_TICKS(CHARGE_TICKS)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .tick_i  (tick),
    .dir_i   (dir),
    .up_o    (up_o),
    .dn_o    (dn_o),
    .state_o (state)
  );

  rlc_meter #(.WW(WW), .BW(BW)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (state == ST_IDLE),
    .track_i     (state == ST_TRACK),
    .tick_i      (tick),
    .dir_i       (dir),
    .win_min_i   (win_min_i),
    .beat_max_i  (beat_max_i),
    .win_conv_o  (win_conv_o),
    .beat_conv_o (beat_conv_o)
  );

  assign lock_o = win_conv_o && beat_conv_o;

  AST_UP_DN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o)); // R5
endmodule

// File: tb/rate_lock_ctrl_test.sv
`timescale 1ns/1ps
module rate_lock_ctrl_test;
  localparam int AW = 5, DIVW = 3, WW = 8, BW = 6, CHG = 8;
  localparam logic [AW-1:0] NOM = 5'd16;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [DIVW-1:0] div_sel_i = '0;
  logic [AW-1:0] wr_ptr_i = NOM, rd_ptr_i = '0;
  logic [WW-1:0] win_min_i = 8'd4;
  logic [BW-1:0] beat_max_i = 6'd10;
  logic up_o, dn_o, win_conv_o, beat_conv_o, lock_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rate_lock_ctrl #(.AW(AW), .DIVW(DIVW), .WW(WW), .BW(BW), .CHARGE_TICKS(CHG)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .div_sel_i(div_sel_i),
    .wr_ptr_i(wr_ptr_i), .rd_ptr_i(rd_ptr_i), .win_min_i(win_min_i),
    .beat_max_i(beat_max_i), .up_o(up_o), .dn_o(dn_o), .win_conv_o(win_conv_o),
    .beat_conv_o(beat_conv_o), .lock_o(lock_o)
  );

  // {div_sel, wr, rd, exp_up, exp_dn}
  localparam logic [14:0] VEC [8] = '{
    {3'd0, 5'd17, 5'd0,  2'b10},
    {3'd0, 5'd0,  5'd17, 2'b01},
    {3'd0, 5'd20, 5'd4,  2'b00},
    {3'd1, 5'd3,  5'd30, 2'b01},
    {3'd2, 5'd30, 5'd3,  2'b10},
    {3'd3, 5'd7,  5'd23, 2'b00},
    {3'd0, 5'd31, 5'd14, 2'b10},
    {3'd1, 5'd14, 5'd31, 2'b01}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input int off, input int n);
    wr_ptr_i = AW'(int'(NOM) + off);
    rd_ptr_i = '0;
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [DIVW-1:0] sel);
    start_i = 1'b0;
    hold(0, 2);
    div_sel_i = sel;
    start_i = 1'b1;
    @(negedge clk);
    repeat ((CHG + 3) << sel) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int first_up, up_cnt;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 up", up_o, 0);
    chk("R1 dn", dn_o, 0);
    chk("R1 flags", {win_conv_o, beat_conv_o, lock_o}, 0);
    rst_ni = 1'b1;

    // R2/R3: charge interval with div_sel=2, pointers ask for DN and are ignored
    @(negedge clk);
    div_sel_i = 3'd2;
    wr_ptr_i = 5'd13; rd_ptr_i = 5'd0;
    start_i = 1'b1;
    first_up = 0; up_cnt = 0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (up_o) begin
        up_cnt++;
        if (first_up == 0) first_up = i;
      end
      if (i <= 36 && dn_o) chk("R3 dn during charge", 1, 0);
    end
    chk("R2 first charge pulse cycle", first_up, 4 + 1);
    chk("R2 R3 charge length", up_cnt, CHG * 4);
    chk("R4 dn after charge", dn_o, 1);

    // R3: start low -> idle
    start_i = 1'b0;
    @(negedge clk);
    chk("R3 idle up", up_o, 0);
    chk("R3 idle dn", dn_o, 0);

    // R4: vector walk
    arm(3'd0);
    for (int v = 0; v < 8; v++) begin
      div_sel_i = VEC[v][14:12];
      wr_ptr_i  = VEC[v][11:7];
      rd_ptr_i  = VEC[v][6:2];
      repeat ((2 << VEC[v][14:12]) + 2) @(negedge clk);
      chk($sformatf("R4 vec%0d up", v), up_o, int'(VEC[v][1]));
      chk($sformatf("R4 vec%0d dn", v), dn_o, int'(VEC[v][0]));
    end

    // R6/R7/R9/R10: convergence with div_sel=0, one tick per cycle
    win_min_i = 8'd4; beat_max_i = 6'd10;
    arm(3'd0);
    hold(1, 5); hold(0, 1);
    chk("R6 window 5 < 8", win_conv_o, 1);
    chk("R7 first burst not timed", beat_conv_o, 0);
    hold(0, 2); hold(1, 1);
    chk("R7 gap 3 < 10", beat_conv_o, 0);
    chk("R4 up in burst", up_o, 1);
    hold(1, 7); hold(0, 1);
    chk("R6 window 8 not < 8", win_conv_o, 0);
    hold(0, 9); hold(1, 1);
    chk("R7 gap 10 >= 10", beat_conv_o, 1);
    chk("R9 no lock", lock_o, 0);
    hold(1, 6); hold(0, 1);
    chk("R6 window 7 < 8", win_conv_o, 1);
    chk("R10 beat flag held", beat_conv_o, 1);
    chk("R9 lock", lock_o, 1);
    hold(0, 8); hold(-1, 1);
    chk("R7 gap 9 < 10", beat_conv_o, 0);
    chk("R4 dn", dn_o, 1);
    chk("R5 up low", up_o, 0);
    hold(-1, 2);
    beat_max_i = 6'd0;
    hold(1, 1);
    chk("R6 reversal window 3", win_conv_o, 1);
    chk("R7 reversal gap 0", beat_conv_o, 1);
    chk("R5 dn low", dn_o, 0);

    // R8: saturation at 63
    beat_max_i = 6'd63;
    hold(0, 62); hold(1, 1);
    chk("R8 gap 62 < 63", beat_conv_o, 0);
    hold(0, 70); hold(1, 1);
    chk("R8 gap 70 saturates", beat_conv_o, 1);

    // R3: flags clear when disarmed
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 flags cleared", {win_conv_o, beat_conv_o, lock_o}, 0);

    // R1: asynchronous reset mid-run
    arm(3'd0);
    hold(1, 3);
    rst_ni = 1'b0;
    #1;
    chk("R1 async up", up_o, 0);
    chk("R1 async flags", {win_conv_o, beat_conv_o}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule